// File: doc/BRIEF.md
# Acquisition Trigger Mode Controller

This block decides which conversion strobes of a data acquisition run become stored samples, based on where they fall relative to a trigger event. A trigger source is picked by a select code: a software pulse, one of several auxiliary lines, a star line, a shared trigger-bus line or a front-panel input. External lines are synchronized to the block clock, and the programmed edge polarity turns the chosen line into a trigger event.

A start command loads the mode and the counts and begins a run. In post mode, sampling begins at the trigger. In pre mode, samples run before the trigger and the trigger ends the run. Middle mode has a sample window on each side of the trigger. Delay mode waits a programmed number of clock periods after the trigger before it starts the post window. Only one trigger is accepted per run. Each accepted trigger is exported as a one-clock pulse, and a one-clock done flag marks the end of the run.

Top module: `acq_trig_ctrl`

## Requirements
- R1: During and directly after reset, `smp_valid`, `trig_out` and `done` are low and no run is active.
- R2: `cfg_src` selects the trigger: 0 is `sw_trig` (a one-cycle pulse, no polarity), 1 to 8 are `aux_trig[0]` to `aux_trig[7]`, 9 is `star_trig`, 10 is `bus_trig` and 11 is `panel_trig`. Codes 12 to 15 select nothing. Activity on a line that is not selected never produces a trigger.
- R3: External lines pass through a two-flop synchronizer. With `cfg_pol`=0 a rising edge is the event, and with `cfg_pol`=1 a falling edge is; the opposite edge is ignored.
- R4: Post mode (`cfg_mode`=0): strobes before the trigger give no samples. After the trigger, each `conv_strobe` high at a clock edge gives `smp_valid` high for the following cycle, up to `cfg_post` samples. A `cfg_post` of 0 counts as 1.
- R5: Pre mode (`cfg_mode`=1): from start, strobes give samples. A trigger before `cfg_pre` samples have been taken is ignored. After that, sampling continues until a trigger, which ends the run with `done`.
- R6: Middle mode (`cfg_mode`=2): same early-trigger suppression as R5. After the trigger, exactly `cfg_post` further samples are taken and the run ends.
- R7: Delay mode (`cfg_mode`=3): after the trigger the block waits `cfg_delay` clock periods (0 counts as 1) and then takes `cfg_post` samples. With `conv_strobe` held high, the first `smp_valid` comes `cfg_delay`+1 cycles after `trig_out`.
- R8: Every accepted trigger raises `trig_out` for exactly one clock cycle.
- R9: After a trigger is accepted, further triggers are ignored until the run ends. A new `start` aborts any run and re-arms the block.
- R10: `done` is high for exactly one cycle, only in a run that accepted a trigger. In post, middle and delay modes it coincides with the last `smp_valid`. After it, strobes give no samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the delay timebase |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and begin a run |
| cfg_mode | input | 2 | 0 post, 1 pre, 2 middle, 3 delay |
| cfg_src | input | 4 | Trigger source select code |
| cfg_pol | input | 1 | 0 rising edge, 1 falling edge |
| cfg_pre | input | 16 | Samples required before a trigger is accepted |
| cfg_post | input | 16 | Samples taken after the trigger |
| cfg_delay | input | 32 | Delay in clock periods (delay mode) |
| sw_trig | input | 1 | Software trigger pulse |
| aux_trig | input | 8 | Auxiliary trigger lines |
| star_trig | input | 1 | Star trigger line |
| bus_trig | input | 1 | Trigger-bus line |
| panel_trig | input | 1 | Front-panel trigger input |
| conv_strobe | input | 1 | Conversion strobe |
| smp_valid | output | 1 | Strobe accepted as a stored sample |
| trig_out | output | 1 | One-cycle pulse per accepted trigger |
| done | output | 1 | One-cycle end-of-run flag |

## Verification
The bench sends triggers into pre and middle runs before the pre window is full. A design that dropped the qualifier would export a trigger there and stop too soon. It toggles lines that are not selected, and drives the edge opposite to the programmed polarity; a faulty mux or a swapped polarity would start the run. It measures the gap from `trig_out` to the first sample in delay mode, at a normal count and at zero. An off-by-one counter, or a zero count that wraps, would shift that gap or hang the run. It also fires second triggers and a mid-run restart, where a missing latch would pulse `trig_out` twice or fail to re-arm.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic [1:0] {
        MODE_POST = 2'd0,
        MODE_PRE  = 2'd1,
        MODE_MID  = 2'd2,
        MODE_DLY  = 2'd3
    } acq_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RING,
        ST_ARM,
        ST_DELAY,
        ST_POST
    } acq_state_e;

    typedef struct packed {
        logic valid;
        logic trig;
        logic done;
    } acq_out_t;

    localparam int SRC_SOFT = 0;
    localparam int SRC_EXT0 = 1;

    function automatic logic edge_pick(input logic rise, input logic fall, input logic pol);
        return pol ? fall : rise;
    endfunction

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    logic [W-1:0] s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/acq_trig_sel.sv
module acq_trig_sel
    import acq_trig_pkg::*;
#(
    parameter int N_AUX = 8,
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  logic             pol,
    input  logic             sw_trig,
    input  logic [N_AUX-1:0] aux,
    input  logic             star,
    input  logic             bus,
    input  logic             panel,
    output logic             evt
);
    localparam int N_EXT = N_AUX + 3;

    logic [N_EXT-1:0] ext_raw;
    logic [N_EXT-1:0] ext_s;
    logic [N_EXT-1:0] ext_prev;
    logic [N_EXT-1:0] hit;
    logic             sel_hit;

    assign ext_raw = {panel, bus, star, aux};

    acq_trig_sync #(.W(N_EXT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_raw),
        .q   (ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= '0;
        else     ext_prev <= ext_s;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_edge
            assign hit[gi] = edge_pick(ext_s[gi] & ~ext_prev[gi],
                                       ~ext_s[gi] & ext_prev[gi], pol);
        end
    endgenerate

    always_comb begin
        sel_hit = 1'b0;
        if (src == SRC_W'(SRC_SOFT)) sel_hit = sw_trig;
        for (int i = 0; i < N_EXT; i++) begin
            if (src == SRC_W'(SRC_EXT0 + i)) sel_hit = hit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= sel_hit;
    end
endmodule

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
    import acq_trig_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  acq_mode_e        mode,
    input  logic [CNT_W-1:0] pre_cnt,
    input  logic [CNT_W-1:0] post_cnt,
    input  logic [DLY_W-1:0] dly_cnt,
    input  logic             evt,
    input  logic             strobe,
    output acq_out_t         out
);
    localparam logic [CNT_W-1:0] ONE_S = CNT_W'(1);
    localparam logic [DLY_W-1:0] ONE_D = DLY_W'(1);

    acq_state_e       st;
    acq_mode_e        mode_q;
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] post_q;
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] scnt;
    logic [DLY_W-1:0] dcnt;
    logic [CNT_W-1:0] post_eff;
    logic [DLY_W-1:0] dly_eff;

    assign post_eff = (post_cnt == '0) ? ONE_S : post_cnt;
    assign dly_eff  = (dly_q == '0) ? ONE_D : dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            mode_q <= MODE_POST;
            pre_q  <= '0;
            post_q <= ONE_S;
            dly_q  <= '0;
            scnt   <= '0;
            dcnt   <= '0;
            out    <= '0;
        end else begin
            out <= '0;
            if (start) begin
                mode_q <= mode;
                pre_q  <= pre_cnt;
                post_q <= post_eff;
                dly_q  <= dly_cnt;
                scnt   <= '0;
                dcnt   <= '0;
                if (mode == MODE_PRE || mode == MODE_MID)
                    st <= (pre_cnt == '0) ? ST_RING : ST_FILL;
                else
                    st <= ST_ARM;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_FILL: begin
                        if (strobe) begin
                            out.valid <= 1'b1;
                            if (scnt == pre_q - ONE_S) begin
                                st   <= ST_RING;
                                scnt <= '0;
                            end else begin
                                scnt <= scnt + ONE_S;
                            end
                        end
                    end
                    ST_RING: begin
                        if (strobe) out.valid <= 1'b1;
                        if (evt) begin
                            out.trig <= 1'b1;
                            if (mode_q == MODE_PRE) begin
                                out.done <= 1'b1;
                                st       <= ST_IDLE;
                            end else begin
                                st   <= ST_POST;
                                scnt <= '0;
                            end
                        end
                    end
                    ST_ARM: begin
                        if (evt) begin
                            out.trig <= 1'b1;
                            scnt     <= '0;
                            if (mode_q == MODE_DLY) begin
                                st   <= ST_DELAY;
                                dcnt <= dly_eff;
                            end else begin
                                st <= ST_POST;
                            end
                        end
                    end
                    ST_DELAY: begin
                        if (dcnt == ONE_D) st <= ST_POST;
                        else               dcnt <= dcnt - ONE_D;
                    end
                    ST_POST: begin
                        if (strobe) begin
                            out.valid <= 1'b1;
                            if (scnt == post_q - ONE_S) begin
                                out.done <= 1'b1;
                                st       <= ST_IDLE;
                            end else begin
                                scnt <= scnt + ONE_S;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
    import acq_trig_pkg::*;
#(
    parameter int N_AUX = 8,
    parameter int CNT_W = 16,
    parameter int DLY_W = 32,
    parameter int SRC_W = $clog2(N_AUX + 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       cfg_mode,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic             cfg_pol,
    input  logic [CNT_W-1:0] cfg_pre,
    input  logic [CNT_W-1:0] cfg_post,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             sw_trig,
    input  logic [N_AUX-1:0] aux_trig,
    input  logic             star_trig,
    input  logic             bus_trig,
    input  logic             panel_trig,
    input  logic             conv_strobe,
    output logic             smp_valid,
    output logic             trig_out,
    output logic             done
);
    logic     trg_evt;
    acq_out_t run_out;

    acq_trig_sel #(.N_AUX(N_AUX), .SRC_W(SRC_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .src     (cfg_src),
        .pol     (cfg_pol),
        .sw_trig (sw_trig),
        .aux     (aux_trig),
        .star    (star_trig),
        .bus     (bus_trig),
        .panel   (panel_trig),
        .evt     (trg_evt)
    );

    acq_trig_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (acq_mode_e'(cfg_mode)),
        .pre_cnt  (cfg_pre),
        .post_cnt (cfg_post),
        .dly_cnt  (cfg_delay),
        .evt      (trg_evt),
        .strobe   (conv_strobe),
        .out      (run_out)
    );

    assign smp_valid = run_out.valid;
    assign trig_out  = run_out.trig;
    assign done      = run_out.done;
endmodule

// File: rtl/acq_trig_chk.sv
module acq_trig_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic conv_strobe,
    input logic smp_valid,
    input logic trig_out,
    input logic done
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || start) seen_q <= 1'b0;
        else if (trig_out) seen_q <= 1'b1;
    end

    AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(conv_strobe)); // R4
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> !seen_q); // R9
    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
        done |-> (trig_out || seen_q)); // R10
    AST_DONE_LAST_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (done && !trig_out) |-> smp_valid); // R10
endmodule

bind acq_trig_ctrl acq_trig_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .conv_strobe (conv_strobe),
    .smp_valid   (smp_valid),
    .trig_out    (trig_out),
    .done        (done)
);

// File: tb/sim_acq_trig_ctrl.sv
`timescale 1ns/1ps
module sim_acq_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [3:0]  cfg_src = 4'd0;
    logic        cfg_pol = 1'b0;
    logic [15:0] cfg_pre = 16'd0;
    logic [15:0] cfg_post = 16'd1;
    logic [31:0] cfg_delay = 32'd0;
    logic        sw_trig = 1'b0;
    logic [7:0]  aux_trig = 8'd0;
    logic        star_trig = 1'b0;
    logic        bus_trig = 1'b0;
    logic        panel_trig = 1'b0;
    logic        conv_strobe = 1'b0;
    logic        smp_valid, trig_out, done;

    int n_chk = 0, n_err = 0;
    int cyc = 0, n_valid = 0, n_trig = 0, n_done = 0, n_dwv = 0;
    int t_trig = -1, t_first = -1;

    always #10 clk = ~clk;

    acq_trig_ctrl u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
        .cfg_pol(cfg_pol), .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_delay(cfg_delay),
        .sw_trig(sw_trig), .aux_trig(aux_trig), .star_trig(star_trig), .bus_trig(bus_trig),
        .panel_trig(panel_trig), .conv_strobe(conv_strobe),
        .smp_valid(smp_valid), .trig_out(trig_out), .done(done)
    );

    always @(negedge clk) begin
        cyc++;
        if (smp_valid) begin
            n_valid++;
            if (t_trig >= 0 && t_first < 0) t_first = cyc;
        end
        if (trig_out) begin n_trig++; t_trig = cyc; end
        if (done) n_done++;
        if (done && smp_valid) n_dwv++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        n_valid = 0; n_trig = 0; n_done = 0; n_dwv = 0; t_trig = -1; t_first = -1;
    endtask

    task automatic go();
        clr();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            conv_strobe = 1'b1; tick(1); conv_strobe = 1'b0; tick(1);
        end
    endtask

    task automatic fire_sw();
        sw_trig = 1'b1; tick(1); sw_trig = 1'b0; tick(3);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 smp_valid at reset", smp_valid, 0);
        chk("R1 trig_out at reset", trig_out, 0);
        chk("R1 done at reset", done, 0);
        rst = 1'b0; tick(2);
        chk("R1 idle after reset", n_valid + n_trig + n_done, 0);
        fire_sw(); strobes(2);
        chk("R1 no run before start", n_trig + n_valid, 0);
    endtask

    task automatic t_post();
        cfg_mode = 2'd0; cfg_src = 4'd0; cfg_post = 16'd4;
        go();
        strobes(3);
        chk("R4 no samples before trigger", n_valid, 0);
        fire_sw();
        chk("R8 trig_out once", n_trig, 1);
        strobes(6);
        chk("R4 post samples", n_valid, 4);
        chk("R10 done once", n_done, 1);
        chk("R10 done with last sample", n_dwv, 1);
        fire_sw();
        chk("R9 trigger after end ignored", n_trig, 1);
    endtask

    task automatic t_src();
        cfg_mode = 2'd0; cfg_src = 4'd6; cfg_pol = 1'b0; cfg_post = 16'd1;
        go();
        aux_trig[2] = 1'b1; bus_trig = 1'b1; panel_trig = 1'b1; tick(6);
        sw_trig = 1'b1; tick(1); sw_trig = 1'b0; tick(4);
        chk("R2 unselected lines ignored", n_trig, 0);
        aux_trig[5] = 1'b1; tick(6);
        chk("R2 selected aux line triggers", n_trig, 1);
        aux_trig = 8'd0; bus_trig = 1'b0; panel_trig = 1'b0; tick(4);
        strobes(1);
        chk("R2 run completes", n_done, 1);
        cfg_src = 4'd13; go();
        panel_trig = 1'b1; bus_trig = 1'b1; star_trig = 1'b1; aux_trig = 8'hFF; tick(6);
        chk("R2 unused code selects nothing", n_trig, 0);
        panel_trig = 1'b0; bus_trig = 1'b0; star_trig = 1'b0; aux_trig = 8'd0; tick(4);
    endtask

    task automatic t_pol();
        cfg_mode = 2'd0; cfg_src = 4'd9; cfg_pol = 1'b1; cfg_post = 16'd0;
        tick(4);
        go();
        star_trig = 1'b1; tick(6);
        chk("R3 rising edge ignored when falling selected", n_trig, 0);
        star_trig = 1'b0; tick(6);
        chk("R3 falling edge triggers", n_trig, 1);
        strobes(2);
        chk("R4 zero post count takes one sample", n_valid, 1);
        chk("R10 done after single sample", n_done, 1);
        cfg_pol = 1'b0;
    endtask

    task automatic t_pre();
        cfg_mode = 2'd1; cfg_src = 4'd0; cfg_pre = 16'd4;
        go();
        strobes(2);
        fire_sw();
        chk("R5 early trigger ignored", n_trig, 0);
        strobes(5);
        chk("R5 samples before trigger", n_valid, 7);
        fire_sw();
        chk("R5 trigger accepted once armed", n_trig, 1);
        chk("R5 trigger ends run", n_done, 1);
        strobes(2);
        chk("R5 no samples after end", n_valid, 7);
    endtask

    task automatic t_mid();
        cfg_mode = 2'd2; cfg_src = 4'd0; cfg_pre = 16'd3; cfg_post = 16'd5;
        go();
        strobes(1);
        fire_sw();
        chk("R6 early trigger ignored", n_trig, 0);
        strobes(2);
        chk("R6 pre window samples", n_valid, 3);
        fire_sw();
        chk("R6 trigger accepted", n_trig, 1);
        strobes(4);
        chk("R6 not done before post count", n_done, 0);
        strobes(3);
        chk("R6 total samples", n_valid, 8);
        chk("R6 done once", n_done, 1);
    endtask

    task automatic t_delay(input int d, input int gap);
        cfg_mode = 2'd3; cfg_src = 4'd0; cfg_post = 16'd2; cfg_delay = 32'(d);
        go();
        conv_strobe = 1'b1;
        fire_sw();
        tick(d + 8);
        conv_strobe = 1'b0; tick(2);
        chk("R7 trigger to first sample gap", t_first - t_trig, gap);
        chk("R7 post samples after delay", n_valid, 2);
        chk("R7 done", n_done, 1);
    endtask

    task automatic t_restart();
        cfg_mode = 2'd0; cfg_src = 4'd0; cfg_post = 16'd3;
        go();
        fire_sw();
        fire_sw();
        chk("R9 second trigger in run ignored", n_trig, 1);
        strobes(1);
        start = 1'b1; tick(1); start = 1'b0;
        fire_sw();
        chk("R9 restart re-arms", n_trig, 2);
        strobes(3);
        chk("R9 fresh sample count", n_valid, 4);
        chk("R9 done after restart", n_done, 1);
    endtask

    initial begin
        #4000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        t_post();
        t_src();
        t_pol();
        t_pre();
        t_mid();
        t_delay(5, 6);
        t_delay(0, 2);
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule